// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

This block holds two 8-bit up-counters. Each has its own clock-select field, compare value, and a pair of sticky flags: overflow and compare-match. Three prescaled enable strobes come in from outside. Each channel picks one of them with its clock-select field, or stops.

A special clock-select code couples the two channels. Channel 0 selecting it turns the pair into one 16-bit counter, with channel 0 as the high byte and channel 1 as the low byte. Channel 1 selecting it makes channel 1 count the compare-match events of channel 0.

Software reaches all counters, compare values, control fields and flags through a small byte-wide register port. Reads are combinational. Writes take effect at the clock edge.

Top module: `tmr8c_top`

## Requirements
- R1: While `rst` is high at a clock edge, both counters clear to 0x00, all flags clear, both compare registers become 0xFF, and both clock-select fields become 3'b000.
- R2: Clock-select 3'b001, 3'b010 and 3'b011 select `tick[0]`, `tick[1]` and `tick[2]` respectively. Codes 3'b000, 3'b101, 3'b110 and 3'b111 stop the channel.
- R3: Outside cascade operation, each channel adds one at every clock edge where its selected tick is high. Each channel is independent of the other.
- R4: A channel's overflow flag (status bit 0) sets at the edge where its counter goes from 0xFF to 0x00.
- R5: A channel's compare-match flag (status bit 1) sets at the edge where its counter advances while equal to its compare value. It reads as 1 from the following cycle.
- R6: Writing a status register clears each flag whose written bit is 0 and leaves flags written as 1 unchanged. A hardware set in the same cycle as a clearing write leaves the flag set.
- R7: A write to a counter in the same cycle as its increment loads the written value.
- R8: With channel 0's clock-select at 3'b100, the 16-bit value {cnt0, cnt1} advances on channel 1's selected tick. Channel 0 advances only when channel 1 wraps from 0xFF to 0x00.
- R9: In 16-bit mode, channel 0's compare flag sets only when all 16 bits equal {cmp0, cmp1}. Channel 1's compare flag sets when the low byte equals cmp1.
- R10: In 16-bit mode, channel 0's overflow flag sets on the wrap from 0xFFFF to 0x0000. Channel 1's overflow flag does not set.
- R11: With channel 1's clock-select at 3'b100 and channel 0's not at 3'b100, channel 1 adds one for each compare-match event of channel 0. The enables on `tick` have no direct effect on channel 1 in this mode.
- R12: The register map is as follows:
  - 0 is ctrl0 and 1 is ctrl1; the clock-select field is in bits [2:0] and bits [7:3] read 0.
  - 2 is stat0 and 3 is stat1; bits [7:2] read 0.
  - 4 is cnt0 and 5 is cnt1.
  - 6 is cmp0 and 7 is cmp1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 3 | Prescaled count enable strobes |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
The assertions assume that `tick`, `addr`, `wr_en` and `wr_data` are stable and defined at every rising edge. They also assume that reset is asserted at the first edge. The bench drives every input on the falling edge and holds `rst` high from time zero, so these conditions hold. The counter-priority and cascade properties also assume that software does not rewrite the byte whose increment they check. Where the bench writes a counter during an increment, it does so only in the case that the write-priority property itself covers.

// File: rtl/tmr8c_pkg.sv
package tmr8c_pkg;
    localparam int BYTE_W = 8;
    localparam int CKS_W  = 3;
    localparam int N_TICK = 3;
    localparam int ADDR_W = 3;
    localparam int N_CH   = 2;

    localparam logic [CKS_W-1:0] CKS_STOP = 3'b000;
    localparam logic [CKS_W-1:0] CKS_CASC = 3'b100;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'd0,
        MODE_WIDE  = 2'd1,
        MODE_EVENT = 2'd2
    } mode_e;

    typedef struct packed {
        logic cmf;
        logic ovf;
    } flags_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL0 = 3'd0, A_CTRL1 = 3'd1,
        A_STAT0 = 3'd2, A_STAT1 = 3'd3,
        A_CNT0  = 3'd4, A_CNT1  = 3'd5,
        A_CMP0  = 3'd6, A_CMP1  = 3'd7
    } addr_e;

    function automatic logic tick_pick(input logic [CKS_W-1:0] cks,
                                       input logic [N_TICK-1:0] tk);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N_TICK; i++)
            if (cks == CKS_W'(i + 1)) r = tk[i];
        return r;
    endfunction

    function automatic mode_e mode_of(input logic [CKS_W-1:0] c0,
                                      input logic [CKS_W-1:0] c1);
        if (c0 == CKS_CASC)      return MODE_WIDE;
        else if (c1 == CKS_CASC) return MODE_EVENT;
        else                     return MODE_SPLIT;
    endfunction
endpackage

// File: rtl/tmr8c_chan.sv
module tmr8c_chan
    import tmr8c_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         wr_cnt,
    input  logic         wr_cmp,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    input  logic         set_ovf,
    input  logic         set_cmf,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp,
    output flags_t       flags,
    output logic         at_max,
    output logic         at_cmp
);
    assign at_max = (cnt == '1);
    assign at_cmp = (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cmp   <= '1;
            flags <= '0;
        end else begin
            if (wr_cnt)   cnt <= wdata;
            else if (inc) cnt <= cnt + 1'b1;
            if (wr_cmp)   cmp <= wdata;
            flags.ovf <= set_ovf | (flags.ovf & ~(wr_stat & ~wdata[0]));
            flags.cmf <= set_cmf | (flags.cmf & ~(wr_stat & ~wdata[1]));
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && cmp == '1 && flags == '0));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_cnt) |=> (cnt == W'($past(cnt) + 1'b1)));
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt == $past(wdata)));
    assert_ovf_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        set_ovf |=> flags.ovf);
    assert_cmf_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        set_cmf |=> flags.cmf);
endmodule

// File: rtl/tmr8c_route.sv
module tmr8c_route
    import tmr8c_pkg::*;
(
    input  logic [CKS_W-1:0]  cks0,
    input  logic [CKS_W-1:0]  cks1,
    input  logic [N_TICK-1:0] tick,
    input  logic              max0,
    input  logic              max1,
    input  logic              eq0,
    input  logic              eq1,
    output mode_e             mode,
    output logic              inc0,
    output logic              inc1,
    output logic              set_ovf0,
    output logic              set_ovf1,
    output logic              set_cmf0,
    output logic              set_cmf1
);
    logic en0, en1;

    always_comb begin
        mode = mode_of(cks0, cks1);
        en0  = tick_pick(cks0, tick);
        en1  = tick_pick(cks1, tick);
        unique case (mode)
            MODE_WIDE: begin
                inc1     = en1;
                inc0     = en1 & max1;
                set_cmf0 = en1 & eq0 & eq1;
            end
            MODE_EVENT: begin
                inc0     = en0;
                inc1     = en0 & eq0;
                set_cmf0 = en0 & eq0;
            end
            default: begin
                inc0     = en0;
                inc1     = en1;
                set_cmf0 = en0 & eq0;
            end
        endcase
        set_ovf0 = inc0 & max0;
        set_ovf1 = inc1 & max1 & (mode != MODE_WIDE);
        set_cmf1 = inc1 & eq1;
    end

    always_comb begin
        if (mode == MODE_WIDE && inc0)
            assert_hi_needs_lo_wrap_R8: assert (max1);
    end
endmodule

// File: rtl/tmr8c_top.sv
module tmr8c_top
    import tmr8c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TICK-1:0] tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int PAD_CTRL = BYTE_W - CKS_W;
    localparam int PAD_STAT = BYTE_W - $bits(flags_t);

    logic [CKS_W-1:0]  cks   [N_CH];
    logic [BYTE_W-1:0] cnt   [N_CH];
    logic [BYTE_W-1:0] cmp   [N_CH];
    flags_t            flg   [N_CH];
    logic [N_CH-1:0]   inc, set_ovf, set_cmf, at_max, at_cmp;
    logic [N_CH-1:0]   we_cnt, we_cmp, we_stat, we_ctrl;
    mode_e             mode;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign we_ctrl[i] = wr_en && (addr == ADDR_W'(A_CTRL0) + ADDR_W'(i));
        assign we_stat[i] = wr_en && (addr == ADDR_W'(A_STAT0) + ADDR_W'(i));
        assign we_cnt[i]  = wr_en && (addr == ADDR_W'(A_CNT0)  + ADDR_W'(i));
        assign we_cmp[i]  = wr_en && (addr == ADDR_W'(A_CMP0)  + ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst)             cks[i] <= CKS_STOP;
            else if (we_ctrl[i]) cks[i] <= wr_data[CKS_W-1:0];
        end

        tmr8c_chan #(.W(BYTE_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .inc     (inc[i]),
            .wr_cnt  (we_cnt[i]),
            .wr_cmp  (we_cmp[i]),
            .wr_stat (we_stat[i]),
            .wdata   (wr_data),
            .set_ovf (set_ovf[i]),
            .set_cmf (set_cmf[i]),
            .cnt     (cnt[i]),
            .cmp     (cmp[i]),
            .flags   (flg[i]),
            .at_max  (at_max[i]),
            .at_cmp  (at_cmp[i])
        );
    end

    tmr8c_route u_route (
        .cks0     (cks[0]),
        .cks1     (cks[1]),
        .tick     (tick),
        .max0     (at_max[0]),
        .max1     (at_max[1]),
        .eq0      (at_cmp[0]),
        .eq1      (at_cmp[1]),
        .mode     (mode),
        .inc0     (inc[0]),
        .inc1     (inc[1]),
        .set_ovf0 (set_ovf[0]),
        .set_ovf1 (set_ovf[1]),
        .set_cmf0 (set_cmf[0]),
        .set_cmf1 (set_cmf[1])
    );

    always_comb begin
        unique case (addr_e'(addr))
            A_CTRL0: rd_data = {{PAD_CTRL{1'b0}}, cks[0]};
            A_CTRL1: rd_data = {{PAD_CTRL{1'b0}}, cks[1]};
            A_STAT0: rd_data = {{PAD_STAT{1'b0}}, flg[0]};
            A_STAT1: rd_data = {{PAD_STAT{1'b0}}, flg[1]};
            A_CNT0:  rd_data = cnt[0];
            A_CNT1:  rd_data = cnt[1];
            A_CMP0:  rd_data = cmp[0];
            default: rd_data = cmp[1];
        endcase
    end

    assert_wide_lo_wraps_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE && inc[0] && we_cnt == '0) |=> (cnt[1] == '0));
    assert_event_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EVENT && !we_cnt[1] && !(inc[0] && at_cmp[0]))
            |=> $stable(cnt[1]));
    assert_wide_no_lo_ovf_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE && !flg[1].ovf && !we_stat[1]) |=> !flg[1].ovf);
endmodule

// File: tb/tmr8c_top_bench.sv
module tmr8c_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tick = '0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr8c_top u_tmr8c_top (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [1:0] op;   // 0 read-check, 1 write, 2 tick steps
        logic [2:0] a;    // address, or tick mask for steps
        logic [8:0] d;    // data, expected value, or step count
        logic [3:0] r;    // requirement number for messages
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 9'h00, 4'd1},  // R1 ctrl0 reset
        '{2'd0, 3'd6, 9'hFF, 4'd1},  // R1 cmp0 reset
        '{2'd0, 3'd5, 9'h00, 4'd1},  // R1 cnt1 reset
        '{2'd0, 3'd2, 9'h00, 4'd1},  // R1 stat0 reset
        '{2'd1, 3'd0, 9'h01, 4'd2},  // ctrl0 -> tick[0]
        '{2'd1, 3'd1, 9'h02, 4'd2},  // ctrl1 -> tick[1]
        '{2'd2, 3'd1, 9'd5,  4'd3},
        '{2'd0, 3'd4, 9'h05, 4'd3},  // R3 cnt0
        '{2'd0, 3'd5, 9'h00, 4'd2},  // R2 ch1 ignores tick[0]
        '{2'd2, 3'd2, 9'd3,  4'd3},
        '{2'd0, 3'd5, 9'h03, 4'd3},  // R3 cnt1
        '{2'd0, 3'd4, 9'h05, 4'd3},  // R3 cnt0 independent
        '{2'd1, 3'd6, 9'h07, 4'd5},
        '{2'd2, 3'd1, 9'd2,  4'd5},
        '{2'd0, 3'd2, 9'h00, 4'd5},  // R5 reaching cmp alone is no match
        '{2'd2, 3'd1, 9'd1,  4'd5},
        '{2'd0, 3'd2, 9'h02, 4'd5},  // R5 match flag
        '{2'd1, 3'd2, 9'h01, 4'd6},
        '{2'd0, 3'd2, 9'h00, 4'd6},  // R6 clear cmf
        '{2'd1, 3'd4, 9'hFE, 4'd4},
        '{2'd2, 3'd1, 9'd2,  4'd4},
        '{2'd0, 3'd2, 9'h01, 4'd4},  // R4 overflow
        '{2'd1, 3'd2, 9'hFF, 4'd6},
        '{2'd0, 3'd2, 9'h01, 4'd6},  // R6 write 1 keeps
        '{2'd1, 3'd0, 9'h06, 4'd2},
        '{2'd2, 3'd7, 9'd3,  4'd2},
        '{2'd0, 3'd4, 9'h00, 4'd2},  // R2 code 110 stopped
        '{2'd0, 3'd0, 9'h06, 4'd12}  // R12 ctrl readback
    };

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); addr = a; #1;
        chk(rd_data, exp, req);
    endtask

    task automatic step(input logic [2:0] m, input int n);
        @(negedge clk); tick = m;
        repeat (n) @(negedge clk);
        tick = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: rd(VEC[i].a, VEC[i].d[7:0], $sformatf("R%0d vec %0d", VEC[i].r, i));
                2'd1: wr(VEC[i].a, VEC[i].d[7:0]);
                default: step(VEC[i].a, int'(VEC[i].d));
            endcase
        end

        // R12 upper control bits read zero
        wr(3'd0, 8'hF9);
        rd(3'd0, 8'h01, "R12 ctrl upper bits");

        // R7 write beats increment
        @(negedge clk); tick = 3'b001; addr = 3'd4; wr_data = 8'h40; wr_en = 1'b1;
        @(negedge clk); tick = '0; wr_en = 1'b0;
        rd(3'd4, 8'h40, "R7 write priority");

        // R6 set wins over a clearing write
        wr(3'd4, 8'hFF);
        wr(3'd2, 8'h00);
        @(negedge clk); tick = 3'b001; addr = 3'd2; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk); tick = '0; wr_en = 1'b0;
        rd(3'd2, 8'h01, "R6 set beats clear");

        // R1 reset mid-run
        do_reset();
        rd(3'd4, 8'h00, "R1 cnt0 after reset");
        rd(3'd2, 8'h00, "R1 stat0 after reset");
        rd(3'd7, 8'hFF, "R1 cmp1 after reset");
        rd(3'd1, 8'h00, "R1 ctrl1 after reset");

        // R8 16-bit carry
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h04);
        wr(3'd5, 8'hFE);
        step(3'b001, 2);
        rd(3'd4, 8'h01, "R8 high byte carry");
        rd(3'd5, 8'h00, "R8 low byte wrap");
        rd(3'd3, 8'h02, "R9 low byte match");
        rd(3'd2, 8'h00, "R9 partial match no full flag");

        // R10 full wrap
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        step(3'b001, 1);
        rd(3'd2, 8'h03, "R10 full wrap ovf and full match");
        rd(3'd3, 8'h02, "R10 no low ovf");
        rd(3'd4, 8'h00, "R10 high byte wrapped");

        // R9 full match on a non-trivial value
        wr(3'd6, 8'h12); wr(3'd7, 8'h34);
        wr(3'd4, 8'h11); wr(3'd5, 8'h34);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        step(3'b001, 1);
        rd(3'd2, 8'h00, "R9 upper mismatch");
        rd(3'd3, 8'h02, "R9 lower match");
        wr(3'd4, 8'h12); wr(3'd5, 8'h34);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        step(3'b001, 1);
        rd(3'd2, 8'h02, "R9 full match");

        // R11 compare-match event counting
        do_reset();
        wr(3'd0, 8'h01);
        wr(3'd6, 8'h03);
        wr(3'd1, 8'h04);
        step(3'b111, 4);
        rd(3'd5, 8'h01, "R11 one event");
        rd(3'd4, 8'h04, "R11 ch0 count");
        step(3'b001, 256);
        rd(3'd5, 8'h02, "R11 second event");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule